// File: doc/BRIEF.md
# Rotating-Window Interleaved Shared Memory

This block is a word memory shared by up to sixteen cores. Storage is split into sixteen banks, and the bank that holds a 32-bit long is selected by the four lowest bits of its long address. A free-running slot counter turns a fixed rotation. In every clock each core faces exactly one bank, and no two cores face the same bank. Each core's window moves one bank further every clock. Access is granted by time slot, so the block has no arbiter and no request queue.

A core presents one access at a time: a read or a write of a byte, a 16-bit word or a full long. The core's port captures the request and holds it until the core's window reaches the target bank, then performs the bank access. One clock later the port raises a one-cycle ready pulse. For reads, the addressed lane of the fetched long appears on the data output in that same cycle. The wait depends only on the bank distance and the current slot. A core that lays out its data and its timing to follow the rotation sees no stall beyond one clock.

Top module: `rwm_shared_mem`

## Requirements
- R1: While reset is high and in the first cycle after it, every core_ready bit is 0. The slot counter is 0 during reset and advances by one on each clock edge that follows reset.
- R2: Byte address bits [5:2] select the bank, and bits [ADDR_W-1:6] select the row inside it. In a cycle with slot value s, core k faces bank (k + s) mod 16.
- R3: A request is sampled on a clock edge. Let s0 be the slot value in the cycle before that edge and let W = (bank - (k + s0)) mod 16, with 0 counted as 16. Then ready is high in the cycle that follows the W-th clock edge after the sampling edge. W therefore lies between 1 and 16.
- R4: Ready is high for exactly one cycle per accepted request. A new request is accepted in that ready cycle.
- R5: A read of size 2'b10 or 2'b11 returns the whole long.
- R6: A read of size 2'b00 returns the byte at lane addr[1:0], zero-extended in rdata[7:0]. Lanes are little-endian: lane i holds byte address offset i.
- R7: A read of size 2'b01 returns lane pair addr[1] (0 = bytes 1:0, 1 = bytes 3:2), zero-extended in rdata[15:0]. addr[0] is ignored.
- R8: A write changes only the addressed lanes. A byte write takes wdata[7:0], a word write takes wdata[15:0] and a long write takes all 32 bits. All other bytes of the long keep their value.
- R9: While a core's request is pending, a further req on that core is ignored. It produces no extra ready and no memory change.
- R10: Cores run at the same time without interfering, including when several of them target the same bank.
- R11: Suppose a core's read of long L completes its access on an edge, and the same core's request for long L+1 is sampled 16 edges later. That second request waits exactly 1 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | NUM_CORES | Request strobe per core, sampled when the port is idle |
| core_we | input | NUM_CORES | 1 = write, 0 = read |
| core_size | input | 2*NUM_CORES | Access size per core: 00 byte, 01 word, 1x long |
| core_addr | input | NUM_CORES*ADDR_W | Byte address per core |
| core_wdata | input | NUM_CORES*32 | Write data per core, low-aligned |
| core_ready | output | NUM_CORES | One-cycle completion pulse per core |
| core_rdata | output | NUM_CORES*32 | Read result per core, valid while ready is high |

## Verification
Several properties are checked on every cycle. Two cores never access the same bank in one cycle. No pending request waits more than sixteen clocks. Ready only follows a bank access. Captured request fields stay frozen while a second strobe arrives on a busy port. A write never reaches a bank with an empty lane mask. The exact wait for a given slot and address, the lane contents returned for each size and offset, and the survival of neighbouring bytes after a partial write depend on the history of data and time. Only the bench scenarios can show those, and likewise the no-stall timing of a stream that follows the rotation.

// File: rtl/rwm_pkg.sv
`timescale 1ns/1ps
package rwm_pkg;
  localparam int NUM_BANKS = 16;
  localparam int BANK_W    = 4;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_LONG2 = 2'b11
  } acc_size_e;

  // byte-enable mask for the long that contains the access
  function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [1:0] lo);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << lo;
      SZ_WORD: lane_mask = lo[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // replicate low-aligned write data onto every lane it may land in
  function automatic logic [DATA_W-1:0] spread_wdata(acc_size_e sz, logic [DATA_W-1:0] wd);
    case (sz)
      SZ_BYTE: spread_wdata = {4{wd[7:0]}};
      SZ_WORD: spread_wdata = {2{wd[15:0]}};
      default: spread_wdata = wd;
    endcase
  endfunction

  // pull the addressed lane out of a fetched long, zero-extended
  function automatic logic [DATA_W-1:0] pick_lane(acc_size_e sz, logic [1:0] lo,
                                                   logic [DATA_W-1:0] lw);
    logic [DATA_W-1:0] sh;
    sh = lw >> {lo, 3'b000};
    case (sz)
      SZ_BYTE: pick_lane = {24'h0, sh[7:0]};
      SZ_WORD: pick_lane = lo[1] ? {16'h0, lw[31:16]} : {16'h0, lw[15:0]};
      default: pick_lane = lw;
    endcase
  endfunction
endpackage

// File: rtl/rwm_slot_ctr.sv
`timescale 1ns/1ps
module rwm_slot_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= slot + 1'b1;
  end
endmodule

// File: rtl/rwm_bank.sv
`timescale 1ns/1ps
module rwm_bank
  import rwm_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  // one narrow array per lane so each maps onto a plain block RAM
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (en && we && be[l]) mem[row] <= wdata[8*l +: 8];
    end
    always_ff @(posedge clk) begin
      if (en && !we) q <= mem[row];
    end
    assign rdata[8*l +: 8] = q;
  end

  // R8
  be_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (en && we) |-> (be != '0));
endmodule

// File: rtl/rwm_port.sv
`timescale 1ns/1ps
module rwm_port
  import rwm_pkg::*;
#(
  parameter int CORE_ID = 0,
  parameter int ADDR_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BANK_W-1:0] slot,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              hit,
  output logic [BANK_W-1:0] tgt_bank,
  output logic [ADDR_W-7:0] row,
  output logic              acc_we,
  output logic [LANES-1:0]  acc_be,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [BANK_W-1:0] ID = BANK_W'(CORE_ID);

  logic              pending;
  logic              p_we;
  acc_size_e         p_size;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;
  logic [4:0]        wait_cnt;
  logic [BANK_W-1:0] facing;

  assign facing = ID + slot;
  assign hit    = pending && (p_addr[5:2] == facing);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      ready    <= 1'b0;
      wait_cnt <= '0;
    end else begin
      ready <= hit;
      if (hit) begin
        pending <= 1'b0;
      end else if (!pending && req) begin
        pending  <= 1'b1;
        wait_cnt <= '0;
      end else if (pending) begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  // request fields: captured only when the port is idle
  always_ff @(posedge clk) begin
    if (!rst && !pending && req) begin
      p_we    <= we;
      p_size  <= acc_size_e'(size);
      p_addr  <= addr;
      p_wdata <= wdata;
    end
  end

  assign tgt_bank  = p_addr[5:2];
  assign row       = p_addr[ADDR_W-1:6];
  assign acc_we    = p_we;
  assign acc_be    = lane_mask(p_size, p_addr[1:0]);
  assign acc_wdata = spread_wdata(p_size, p_wdata);
  assign rdata     = pick_lane(p_size, p_addr[1:0], bank_rdata);

  // R3
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (wait_cnt < 5'(NUM_BANKS)));
  // R4
  ready_origin_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(hit));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && req) |=> ($stable(p_addr) && $stable(p_we) && $stable(p_wdata)));
endmodule

// File: rtl/rwm_shared_mem.sv
`timescale 1ns/1ps
module rwm_shared_mem
  import rwm_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES-1:0]        core_req,
  input  logic [NUM_CORES-1:0]        core_we,
  input  logic [2*NUM_CORES-1:0]      core_size,
  input  logic [NUM_CORES*ADDR_W-1:0] core_addr,
  input  logic [NUM_CORES*DATA_W-1:0] core_wdata,
  output logic [NUM_CORES-1:0]        core_ready,
  output logic [NUM_CORES*DATA_W-1:0] core_rdata
);
  localparam int ROW_W = ADDR_W - 6;

  logic [BANK_W-1:0] slot;

  // per-window signals, padded to sixteen entries
  logic              p_hit [NUM_BANKS];
  logic [BANK_W-1:0] p_tgt [NUM_BANKS];
  logic [ROW_W-1:0]  p_row [NUM_BANKS];
  logic              p_we  [NUM_BANKS];
  logic [LANES-1:0]  p_be  [NUM_BANKS];
  logic [DATA_W-1:0] p_wd  [NUM_BANKS];
  logic [DATA_W-1:0] b_rd  [NUM_BANKS];

  rwm_slot_ctr #(.W(BANK_W)) u_slot (
    .clk  (clk),
    .rst  (rst),
    .slot (slot)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_core
    if (k < NUM_CORES) begin : g_live
      rwm_port #(.CORE_ID(k), .ADDR_W(ADDR_W)) u_port (
        .clk        (clk),
        .rst        (rst),
        .req        (core_req[k]),
        .we         (core_we[k]),
        .size       (core_size[2*k +: 2]),
        .addr       (core_addr[ADDR_W*k +: ADDR_W]),
        .wdata      (core_wdata[DATA_W*k +: DATA_W]),
        .slot       (slot),
        .bank_rdata (b_rd[p_tgt[k]]),
        .hit        (p_hit[k]),
        .tgt_bank   (p_tgt[k]),
        .row        (p_row[k]),
        .acc_we     (p_we[k]),
        .acc_be     (p_be[k]),
        .acc_wdata  (p_wd[k]),
        .ready      (core_ready[k]),
        .rdata      (core_rdata[DATA_W*k +: DATA_W])
      );
    end else begin : g_pad
      assign p_hit[k] = 1'b0;
      assign p_tgt[k] = '0;
      assign p_row[k] = '0;
      assign p_we[k]  = 1'b0;
      assign p_be[k]  = '0;
      assign p_wd[k]  = '0;
    end
  end

  // bank b is faced by window (b - slot) mod 16 in the current cycle
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] fc;
    assign fc = BANK_W'(b) - slot;

    rwm_bank #(.ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .en    (p_hit[fc]),
      .we    (p_we[fc]),
      .be    (p_be[fc]),
      .row   (p_row[fc]),
      .wdata (p_wd[fc]),
      .rdata (b_rd[b])
    );
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_pair_i
    for (genvar j = i + 1; j < NUM_CORES; j++) begin : g_pair_j
      // R10
      bank_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (p_hit[i] && p_hit[j]) |-> (p_tgt[i] != p_tgt[j]));
    end
  end
endmodule

// File: tb/rwm_shared_mem_tb.sv
`timescale 1ns/1ps
module rwm_shared_mem_tb;
  localparam int NC = 4;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NC-1:0]    req, we;
  logic [2*NC-1:0]  size;
  logic [NC*AW-1:0] addr;
  logic [NC*32-1:0] wdata;
  logic [NC-1:0]    ready;
  logic [NC*32-1:0] rdata;

  logic        r_req [NC];
  logic        r_we  [NC];
  logic [1:0]  r_sz  [NC];
  logic [AW-1:0] r_ad [NC];
  logic [31:0] r_wd  [NC];

  always_comb begin
    for (int k = 0; k < NC; k++) begin
      req[k]            = r_req[k];
      we[k]             = r_we[k];
      size[2*k +: 2]    = r_sz[k];
      addr[AW*k +: AW]  = r_ad[k];
      wdata[32*k +: 32] = r_wd[k];
    end
  end

  rwm_shared_mem #(.NUM_CORES(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .core_req(req), .core_we(we), .core_size(size),
    .core_addr(addr), .core_wdata(wdata), .core_ready(ready), .core_rdata(rdata)
  );

  // slot model from R1/R2: 0 in reset, +1 per clock afterwards
  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int rdy_cnt [NC];
  always @(negedge clk) begin
    for (int k = 0; k < NC; k++) if (ready[k] === 1'b1) rdy_cnt[k] <= rdy_cnt[k] + 1;
  end

  logic [7:0] refm [1 << AW];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [AW-1:0] a, logic [1:0] sz);
    logic [AW-1:0] base;
    logic [31:0] lw;
    base = {a[AW-1:2], 2'b00};
    lw = {refm[base + 3], refm[base + 2], refm[base + 1], refm[base]};
    case (sz)
      2'b00:   return {24'h0, 8'(lw >> (8 * a[1:0]))};
      2'b01:   return a[1] ? {16'h0, lw[31:16]} : {16'h0, lw[15:0]};
      default: return lw;
    endcase
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] wd);
    logic [AW-1:0] base;
    case (sz)
      2'b00: refm[a] = wd[7:0];
      2'b01: begin
        base = {a[AW-1:1], 1'b0};
        refm[base] = wd[7:0];
        refm[base + 1] = wd[15:8];
      end
      default: begin
        base = {a[AW-1:2], 2'b00};
        for (int i = 0; i < 4; i++) refm[base + i] = wd[8*i +: 8];
      end
    endcase
  endtask

  // called at a negedge; returns at the negedge of the ready cycle
  task automatic op(input int c, input logic w, input logic [1:0] sz, input logic [AW-1:0] a,
                    input logic [31:0] wd, output int n, output int w_exp, output logic [31:0] rd);
    int face, bank;
    face  = (c + cyc) % 16;
    bank  = int'(a[5:2]);
    w_exp = (bank - face + 16) % 16;
    if (w_exp == 0) w_exp = 16;
    if (w) model_wr(a, sz, wd);
    r_req[c] = 1'b1; r_we[c] = w; r_sz[c] = sz; r_ad[c] = a; r_wd[c] = wd;
    @(posedge clk);
    @(negedge clk);
    r_req[c] = 1'b0;
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (ready[c] === 1'b1 || n > 40) break;
    end
    rd = rdata[32*c +: 32];
  endtask

  // core, we, size, addr, wdata
  localparam logic [46:0] VEC [14] = '{
    {2'd0, 1'b1, 2'b10, 10'h040, 32'hA1B2C3D4},
    {2'd1, 1'b0, 2'b10, 10'h040, 32'h0},
    {2'd2, 1'b0, 2'b00, 10'h041, 32'h0},
    {2'd3, 1'b0, 2'b00, 10'h043, 32'h0},
    {2'd0, 1'b0, 2'b01, 10'h042, 32'h0},
    {2'd1, 1'b0, 2'b01, 10'h041, 32'h0},
    {2'd2, 1'b1, 2'b00, 10'h042, 32'hFFFF00EE},
    {2'd3, 1'b0, 2'b11, 10'h040, 32'h0},
    {2'd0, 1'b1, 2'b10, 10'h3FC, 32'h11223344},
    {2'd1, 1'b1, 2'b01, 10'h3FE, 32'hFFFF5A5A},
    {2'd2, 1'b0, 2'b10, 10'h3FC, 32'h0},
    {2'd3, 1'b1, 2'b00, 10'h3FC, 32'h00000077},
    {2'd0, 1'b0, 2'b10, 10'h3FC, 32'h0},
    {2'd1, 1'b0, 2'b00, 10'h3FD, 32'h0}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, we_, c0;
    logic [31:0] rd, ex;
    for (int k = 0; k < NC; k++) begin
      r_req[k] = 0; r_we[k] = 0; r_sz[k] = 0; r_ad[k] = '0; r_wd[k] = '0; rdy_cnt[k] = 0;
    end
    repeat (4) @(negedge clk);
    chk(ready == '0, "R1 ready in reset", 32'(ready), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == '0, "R1 ready after reset", 32'(ready), 32'h0);

    // first access right after reset: wait follows a slot that started at 0
    op(1, 1'b1, 2'b10, 10'h0C0, 32'hCAFE0001, n, we_, rd);
    chk(n == we_, "R1 R3 first wait", 32'(n), 32'(we_));

    // fill the memory so every later read is defined
    for (int i = 0; i < (1 << (AW - 2)); i++) begin
      op(i % NC, 1'b1, 2'b10, AW'(i * 4), 32'h9E3779B9 * (i + 1), n, we_, rd);
    end

    // vector table
    for (int v = 0; v < 14; v++) begin
      logic [46:0] e;
      string tg;
      e = VEC[v];
      ex = model_rd(e[41:32], e[43:42]);
      op(int'(e[46:45]), e[44], e[43:42], e[41:32], e[31:0], n, we_, rd);
      chk(n == we_, "R2 R3 wait", 32'(n), 32'(we_));
      if (!e[44]) begin
        tg = (e[43:42] == 2'b00) ? "R6 R8 byte read" :
             (e[43:42] == 2'b01) ? "R7 R8 word read" : "R5 R8 long read";
        chk(rd == ex, tg, rd, ex);
      end
      @(negedge clk);
      chk(ready[e[46:45]] == 1'b0, "R4 one-cycle ready", 32'(ready), 32'h0);
    end

    // R9: strobe on a busy port, aimed at a long that must stay intact
    c0 = rdy_cnt[0];
    ex = model_rd(10'h040, 2'b10);
    fork
      begin
        logic [AW-1:0] a;
        a = {4'h2, 4'((0 + cyc) % 16), 2'b00};
        op(0, 1'b0, 2'b10, a, 32'h0, n, we_, rd);
      end
      begin
        repeat (3) @(negedge clk);
        r_req[0] = 1'b1; r_we[0] = 1'b1; r_sz[0] = 2'b10; r_ad[0] = 10'h040; r_wd[0] = 32'h0;
        @(negedge clk);
        r_req[0] = 1'b0;
      end
    join
    chk(n == 16, "R3 full-rotation wait", 32'(n), 32'd16);
    repeat (20) @(negedge clk);
    chk(rdy_cnt[0] == c0 + 1, "R9 no extra ready", 32'(rdy_cnt[0] - c0), 32'd1);
    op(1, 1'b0, 2'b10, 10'h040, 32'h0, n, we_, rd);
    chk(rd == ex, "R9 memory untouched", rd, ex);

    // R10: all cores at once, two writers and two readers on bank 5
    begin
      int n0, n1, n2, n3, e0, e1, e2, e3;
      logic [31:0] d0, d1, d2, d3, x2, x3;
      x2 = model_rd({4'h6, 4'h5, 2'b00}, 2'b10);
      x3 = model_rd({4'h7, 4'h5, 2'b10}, 2'b01);
      fork
        op(0, 1'b1, 2'b10, {4'h3, 4'h5, 2'b00}, 32'h0C0C0001, n0, e0, d0);
        op(1, 1'b1, 2'b10, {4'h4, 4'h5, 2'b00}, 32'h1D1D0002, n1, e1, d1);
        op(2, 1'b0, 2'b10, {4'h6, 4'h5, 2'b00}, 32'h0, n2, e2, d2);
        op(3, 1'b0, 2'b01, {4'h7, 4'h5, 2'b10}, 32'h0, n3, e3, d3);
      join
      chk(n0 == e0, "R10 core0 wait", 32'(n0), 32'(e0));
      chk(n1 == e1, "R10 core1 wait", 32'(n1), 32'(e1));
      chk(n2 == e2, "R10 core2 wait", 32'(n2), 32'(e2));
      chk(n3 == e3, "R10 core3 wait", 32'(n3), 32'(e3));
      chk(d2 == x2, "R10 core2 data", d2, x2);
      chk(d3 == x3, "R10 core3 data", d3, x3);
      @(negedge clk);
      fork
        op(3, 1'b0, 2'b10, {4'h3, 4'h5, 2'b00}, 32'h0, n3, e3, d3);
        op(2, 1'b0, 2'b10, {4'h4, 4'h5, 2'b00}, 32'h0, n2, e2, d2);
      join
      chk(d3 == 32'h0C0C0001, "R10 cross read core3", d3, 32'h0C0C0001);
      chk(d2 == 32'h1D1D0002, "R10 cross read core2", d2, 32'h1D1D0002);
    end

    // R11: stream of consecutive longs that follows the rotation
    op(2, 1'b0, 2'b10, 10'h140, 32'h0, n, we_, rd);
    for (int i = 1; i < 4; i++) begin
      logic [AW-1:0] a;
      a = AW'(10'h140 + 4 * i);
      ex = model_rd(a, 2'b10);
      repeat (15) @(negedge clk);
      op(2, 1'b0, 2'b10, a, 32'h0, n, we_, rd);
      chk(n == 1, "R11 in-sync wait", 32'(n), 32'd1);
      chk(rd == ex, "R11 stream data", rd, ex);
    end

    finish_run();
  end
endmodule